// File: doc/BRIEF.md
# Scrambling Key Holder with Escalation Wipe

This block holds the key, nonce and seed-provisioned flag that a memory scrambler uses. After reset it presents fixed default constants, so the memory can be used at once. On a renew request it runs a four-phase req/ack handshake with a key provider. When the provider acknowledges, the block captures the new key, the new nonce and the provider's seed-provisioned flag. While a fetch is outstanding, bus accesses are held off.

Escalation comes from a multibit lifecycle input that is anything other than the Off code, or from a local integrity error or counter error. On escalation the key material returns to the defaults and the block latches a permanent block on all memory accesses until reset. An integrity error also latches a fatal alert. A software lock can be cleared once to stop further renew and initialization requests. Initialization requests are passed on as a start pulse, held back until any key fetch has completed.

Top module: `sram_key_ctrl`

## Requirements
- R1: Once reset is released, `key_o` equals parameter `DefKey` and `nonce_o` equals `DefNonce`. `key_valid_o`, `seed_valid_o`, `key_req_o`, `escalated_o`, `fatal_integ_o` and `init_go_o` are 0 and `regwen_o` is 1. A bus request is granted at once.
- R2: A `renew_i` pulse is accepted when `regwen_o`=1, no fetch is outstanding and the block is not escalated. `key_req_o` rises in the next cycle and stays high until the cycle in which `key_ack_i` is seen. A renew while `key_req_o` is high starts no second fetch.
- R3: When `key_ack_i` is high while `key_req_o` is high, the cycle after shows `key_i`, `nonce_i` and `seed_i` (captured in that ack cycle) on `key_o`, `nonce_o` and `seed_valid_o`. In that same following cycle `key_valid_o`=1 and `key_req_o`=0.
- R4: `key_valid_o` goes to 0 in the cycle after a renew is accepted.
- R5: While `key_req_o` is high, a bus request gets `bus_gnt_o`=0 and `bus_stall_o`=1. The ack cycle itself is included. The request is granted again in the cycle after the ack.
- R6: If `lc_esc_i` differs from parameter `LcOff` (default 4'b1010), then in the next cycle `key_o`=`DefKey`, `nonce_o`=`DefNonce`, `key_valid_o`=0, `seed_valid_o`=0 and `escalated_o`=1. `escalated_o` stays 1 until reset.
- R7: A pulse on `integ_err_i` or on `cnt_err_i` has the same effect as R6.
- R8: Bus requests are denied from the cycle the escalation input is seen, and for ever after. An escalation drops `key_req_o` in the next cycle. Renew requests and late acks are then ignored.
- R9: An `integ_err_i` pulse sets `fatal_integ_o` in the next cycle until reset. `cnt_err_i` and `lc_esc_i` do not set it.
- R10: A `lock_i` pulse clears `regwen_o` in the next cycle until reset. From then on, `renew_i` and `init_i` have no effect.
- R11: An `init_i` accepted while no fetch is outstanding or starting gives a one-cycle `init_go_o` pulse in the next cycle.
- R12: An `init_i` that arrives with a renew, or while a fetch is outstanding, gives its `init_go_o` pulse in the cycle the new key appears on `key_o`, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| renew_i | input | 1 | Software request for a fresh key |
| init_i | input | 1 | Software request for memory initialization |
| lock_i | input | 1 | Clears the control write enable |
| key_req_o | output | 1 | Handshake request to key provider |
| key_ack_i | input | 1 | Handshake acknowledge from key provider |
| key_i | input | KeyW | Key from provider |
| nonce_i | input | NonceW | Nonce from provider |
| seed_i | input | 1 | Provider's seed-provisioned flag |
| lc_esc_i | input | LcW | Multibit lifecycle escalation |
| integ_err_i | input | 1 | Local bus integrity error |
| cnt_err_i | input | 1 | Local counter error |
| bus_req_i | input | 1 | Memory access request |
| bus_gnt_o | output | 1 | Access granted this cycle |
| bus_stall_o | output | 1 | Access held off this cycle |
| key_o | output | KeyW | Current scrambling key |
| nonce_o | output | NonceW | Current scrambling nonce |
| key_valid_o | output | 1 | Fresh key loaded |
| seed_valid_o | output | 1 | Loaded key came from provisioned seeds |
| escalated_o | output | 1 | Escalation latched |
| fatal_integ_o | output | 1 | Latched integrity alert |
| regwen_o | output | 1 | Control write enable |
| init_go_o | output | 1 | Initialization start pulse |

## Verification
The bench targets the ack cycle. A design that releases the stall one cycle early would grant an access that still sees the old key, and the stall check in the ack cycle catches it. Escalation is driven both while idle and in the middle of a fetch, with a late ack afterwards. A design that let that ack through would show a provider key after the wipe. Lifecycle codes only one bit away from Off are applied, so a decoder that checks a single bit would miss them. A counter error must not raise the fatal alert. An init that comes with a renew must wait for the key, and a premature pulse would show up while the fetch is still outstanding.

// File: rtl/sram_key_pkg.sv
package sram_key_pkg;
  typedef enum logic [1:0] {HsIdle, HsReq, HsDrain} hs_state_e;
  localparam int unsigned LcWidth = 4;
  localparam logic [LcWidth-1:0] LcOffCode = 4'b1010;
endpackage

// File: rtl/key_hs_fsm.sv
module key_hs_fsm
  import sram_key_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic ack_i,
  output logic req_o,
  output logic idle_o,
  output logic done_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HsIdle:  if (start_i && !abort_i) state_d = HsReq;
      HsReq:   if (abort_i || ack_i) state_d = HsDrain;
      HsDrain: if (!ack_i) state_d = HsIdle;
      default: state_d = HsIdle;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HsIdle;
    else         state_q <= state_d;
  end

  assign req_o  = (state_q == HsReq);
  assign idle_o = (state_q == HsIdle);
  assign done_o = req_o && ack_i && !abort_i;

  // four-phase: once request is withdrawn it is not re-raised before ack drops
  p_no_reraise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HsDrain && ack_i) |=> !req_o);
endmodule

// File: rtl/key_store.sv
module key_store #(
  parameter int unsigned KeyW   = 128,
  parameter int unsigned NonceW = 64,
  parameter logic [KeyW-1:0]   DefKey   = '0,
  parameter logic [NonceW-1:0] DefNonce = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wipe_i,
  input  logic [KeyW-1:0]   key_i,
  input  logic [NonceW-1:0] nonce_i,
  input  logic              seed_i,
  output logic [KeyW-1:0]   key_o,
  output logic [NonceW-1:0] nonce_o,
  output logic              seed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o   <= DefKey;
      nonce_o <= DefNonce;
      seed_o  <= 1'b0;
    end else if (wipe_i) begin
      key_o   <= DefKey;
      nonce_o <= DefNonce;
      seed_o  <= 1'b0;
    end else if (load_i) begin
      key_o   <= key_i;
      nonce_o <= nonce_i;
      seed_o  <= seed_i;
    end
  end

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wipe_i) |=> (key_o == $past(key_i) && nonce_o == $past(nonce_i)));
endmodule

// File: rtl/esc_ctrl.sv
module esc_ctrl #(
  parameter int unsigned LcW = 4,
  parameter logic [LcW-1:0] LcOff = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [LcW-1:0] lc_esc_i,
  input  logic           integ_err_i,
  input  logic           cnt_err_i,
  output logic           esc_now_o,
  output logic           escalated_o,
  output logic           fatal_o
);
  assign esc_now_o = (lc_esc_i != LcOff) || integ_err_i || cnt_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      escalated_o <= 1'b0;
      fatal_o     <= 1'b0;
    end else begin
      if (esc_now_o)   escalated_o <= 1'b1;
      if (integ_err_i) fatal_o     <= 1'b1;
    end
  end

  p_esc_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    escalated_o |=> escalated_o);
  p_fatal_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
  p_fatal_only_integ_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fatal_o) |-> $past(integ_err_i));
endmodule

// File: rtl/sram_key_ctrl.sv
module sram_key_ctrl
  import sram_key_pkg::*;
#(
  parameter int unsigned KeyW   = 128,
  parameter int unsigned NonceW = 64,
  parameter int unsigned LcW    = LcWidth,
  parameter logic [KeyW-1:0]   DefKey   = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0,
  parameter logic [NonceW-1:0] DefNonce = 64'h5a5ac3c31234abcd,
  parameter logic [LcW-1:0]    LcOff    = LcOffCode
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              renew_i,
  input  logic              init_i,
  input  logic              lock_i,
  output logic              key_req_o,
  input  logic              key_ack_i,
  input  logic [KeyW-1:0]   key_i,
  input  logic [NonceW-1:0] nonce_i,
  input  logic              seed_i,
  input  logic [LcW-1:0]    lc_esc_i,
  input  logic              integ_err_i,
  input  logic              cnt_err_i,
  input  logic              bus_req_i,
  output logic              bus_gnt_o,
  output logic              bus_stall_o,
  output logic [KeyW-1:0]   key_o,
  output logic [NonceW-1:0] nonce_o,
  output logic              key_valid_o,
  output logic              seed_valid_o,
  output logic              escalated_o,
  output logic              fatal_integ_o,
  output logic              regwen_o,
  output logic              init_go_o
);
  logic esc_now, blocked, hs_idle, hs_done;
  logic renew_ok, init_ok;
  logic regwen_q, key_valid_q, init_wait_q, init_go_q;

  esc_ctrl #(.LcW(LcW), .LcOff(LcOff)) u_esc (
    .clk_i, .rst_ni,
    .lc_esc_i, .integ_err_i, .cnt_err_i,
    .esc_now_o   (esc_now),
    .escalated_o (escalated_o),
    .fatal_o     (fatal_integ_o)
  );

  assign blocked  = escalated_o || esc_now;
  assign renew_ok = renew_i && regwen_q && !blocked && hs_idle;
  assign init_ok  = init_i && regwen_q && !blocked;

  key_hs_fsm u_hs (
    .clk_i, .rst_ni,
    .start_i (renew_ok),
    .abort_i (blocked),
    .ack_i   (key_ack_i),
    .req_o   (key_req_o),
    .idle_o  (hs_idle),
    .done_o  (hs_done)
  );

  key_store #(.KeyW(KeyW), .NonceW(NonceW), .DefKey(DefKey), .DefNonce(DefNonce)) u_store (
    .clk_i, .rst_ni,
    .load_i  (hs_done),
    .wipe_i  (blocked),
    .key_i, .nonce_i, .seed_i,
    .key_o, .nonce_o,
    .seed_o  (seed_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regwen_q    <= 1'b1;
      key_valid_q <= 1'b0;
      init_wait_q <= 1'b0;
      init_go_q   <= 1'b0;
    end else begin
      if (lock_i) regwen_q <= 1'b0;
      if (blocked)       key_valid_q <= 1'b0;
      else if (renew_ok) key_valid_q <= 1'b0;
      else if (hs_done)  key_valid_q <= 1'b1;
      // init waits for a fetch in flight, releases with the key load
      init_wait_q <= !blocked && !hs_done &&
                     (init_wait_q || (init_ok && (renew_ok || key_req_o)));
      init_go_q   <= !blocked &&
                     ((init_ok && !renew_ok && !key_req_o) ||
                      ((init_wait_q || init_ok) && hs_done));
    end
  end

  assign regwen_o    = regwen_q;
  assign key_valid_o = key_valid_q;
  assign init_go_o   = init_go_q;
  assign bus_gnt_o   = bus_req_i && !key_req_o && !blocked;
  assign bus_stall_o = bus_req_i && !bus_gnt_o;

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_req_o && !key_ack_i && !esc_now) |=> key_req_o);
  p_valid_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_req_o && key_ack_i && !esc_now) |=> (key_valid_o && !key_req_o));
  p_valid_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (renew_i && regwen_o && !key_req_o && !escalated_o && !esc_now && !$past(key_req_o))
      |=> !key_valid_o);
  p_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_req_o && bus_req_i) |-> (bus_stall_o && !bus_gnt_o));
  p_wipe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_now |=> (key_o == DefKey && nonce_o == DefNonce && !key_valid_o && escalated_o));
  p_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    escalated_o |-> (!bus_gnt_o && !key_req_o));
  p_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regwen_o |=> (!regwen_o && !$rose(key_req_o)));
  p_init_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_go_o |-> !key_req_o);
endmodule

// File: tb/sram_key_ctrl_tb.sv
module sram_key_ctrl_tb;
  localparam int unsigned ClkPeriod = 10;
  localparam int unsigned KW = 128;
  localparam int unsigned NW = 64;
  localparam logic [KW-1:0] DK = 128'hdead_beef_0123_4567_89ab_cdef_f00d_cafe;
  localparam logic [NW-1:0] DN = 64'h1357_9bdf_2468_ace0;
  localparam logic [3:0]    OFF = 4'b1010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic renew = 0, init = 0, lock = 0, ack = 0, seed = 0, ierr = 0, cerr = 0, breq = 0;
  logic [KW-1:0] key = '0;
  logic [NW-1:0] nonce = '0;
  logic [3:0] lc = OFF;
  logic req, gnt, stall, kv, sv, esc, fatal, regwen, igo;
  logic [KW-1:0] key_q;
  logic [NW-1:0] nonce_q;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(ClkPeriod/2) clk = ~clk;

  sram_key_ctrl #(.KeyW(KW), .NonceW(NW), .DefKey(DK), .DefNonce(DN), .LcOff(OFF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .renew_i(renew), .init_i(init), .lock_i(lock),
    .key_req_o(req), .key_ack_i(ack), .key_i(key), .nonce_i(nonce), .seed_i(seed),
    .lc_esc_i(lc), .integ_err_i(ierr), .cnt_err_i(cerr), .bus_req_i(breq),
    .bus_gnt_o(gnt), .bus_stall_o(stall), .key_o(key_q), .nonce_o(nonce_q),
    .key_valid_o(kv), .seed_valid_o(sv), .escalated_o(esc), .fatal_integ_o(fatal),
    .regwen_o(regwen), .init_go_o(igo)
  );

  task automatic chk(string tag, logic [KW-1:0] act, logic [KW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; renew = 0; init = 0; lock = 0; ack = 0; ierr = 0; cerr = 0; breq = 0; lc = OFF;
    repeat (2) nxt();
    rst_n = 1;
    nxt();
  endtask

  // drive ack with given material; returns at the cycle after ack
  task automatic provide(logic [KW-1:0] k, logic [NW-1:0] n, logic s);
    ack = 1; key = k; nonce = n; seed = s; breq = 1; #1;
    chk("R5 stall in ack cycle", stall, 1);
    nxt();
    ack = 0; #1;
    chk("R5 grant after ack", gnt, 1);
    breq = 0;
  endtask

  task automatic t_reset();
    chk("R1 key", key_q, DK);
    chk("R1 nonce", nonce_q, DN);
    chk("R1 flags", {kv, sv, req, esc, fatal, igo, regwen}, 7'b0000001);
    breq = 1; #1;
    chk("R1 grant", gnt, 1);
    breq = 0;
  endtask

  task automatic t_renew(logic [KW-1:0] k, logic [NW-1:0] n, logic s);
    renew = 1; nxt(); renew = 0;
    chk("R2 req raised", req, 1);
    chk("R4 valid cleared", kv, 0);
    breq = 1; #1;
    chk("R5 stall pending", {gnt, stall}, 2'b01);
    breq = 0;
    renew = 1; nxt(); renew = 0;
    repeat (2) nxt();
    chk("R2 req held", req, 1);
    provide(k, n, s);
    chk("R3 key", key_q, k);
    chk("R3 nonce", nonce_q, n);
    chk("R3 seed", sv, s);
    chk("R3 valid/req", {kv, req}, 2'b10);
    repeat (3) nxt();
    chk("R2 no second fetch", req, 0);
  endtask

  task automatic t_init_idle();
    init = 1; nxt(); init = 0;
    chk("R11 init pulse", igo, 1);
    nxt();
    chk("R11 pulse one cycle", igo, 0);
  endtask

  task automatic t_init_with_renew();
    renew = 1; init = 1; nxt(); renew = 0; init = 0;
    chk("R12 init held", igo, 0);
    nxt();
    chk("R12 init held pending", igo, 0);
    provide(128'h77, 64'h88, 1);
    chk("R12 init with key", {igo, key_q == 128'h77}, 2'b11);
    nxt();
    chk("R12 single pulse", igo, 0);
  endtask

  task automatic t_lock();
    lock = 1; nxt(); lock = 0;
    chk("R10 regwen cleared", regwen, 0);
    renew = 1; init = 1; nxt(); renew = 0; init = 0;
    chk("R10 renew/init ignored", {req, igo, kv}, 3'b001);
    nxt();
    chk("R10 still locked", {regwen, req}, 2'b00);
  endtask

  task automatic t_esc_lc(logic [3:0] code);
    lc = code; breq = 1; #1;
    chk("R8 same-cycle deny", gnt, 0);
    nxt(); lc = OFF;
    chk("R6 key wiped", key_q, DK);
    chk("R6 nonce wiped", nonce_q, DN);
    chk("R6 flags", {kv, sv, esc, fatal}, 4'b0010);
    nxt(); #1;
    chk("R8 deny sticky", {gnt, esc}, 2'b01);
    breq = 0;
    renew = 1; nxt(); renew = 0;
    chk("R8 renew ignored", req, 0);
  endtask

  task automatic t_esc_mid_fetch();
    renew = 1; nxt(); renew = 0;
    cerr = 1; nxt(); cerr = 0;
    chk("R8 req dropped", req, 0);
    chk("R7 cnt err escalates", esc, 1);
    chk("R9 cnt err not fatal", fatal, 0);
    ack = 1; key = 128'hbad; nonce = 64'hbad; seed = 1; nxt(); ack = 0;
    nxt();
    chk("R8 late ack ignored", key_q, DK);
  endtask

  task automatic t_integ();
    ierr = 1; nxt(); ierr = 0;
    chk("R7 integ wipe", {key_q == DK, esc, kv}, 3'b110);
    chk("R9 fatal set", fatal, 1);
    repeat (3) nxt();
    chk("R9 fatal held", fatal, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_renew(128'h1111_2222_3333_4444_5555_6666_7777_8888, 64'habcd_0001_abcd_0002, 1);
    t_renew(128'h9999_aaaa_bbbb_cccc_dddd_eeee_ffff_0000, 64'h0102_0304_0506_0708, 0);
    t_init_idle();
    t_init_with_renew();
    t_lock();
    do_reset();
    t_renew(128'h4242, 64'h4343, 1);
    t_esc_lc(4'b1011);
    do_reset();
    t_renew(128'h5151, 64'h5252, 1);
    t_esc_lc(4'b0010);
    do_reset();
    t_esc_mid_fetch();
    do_reset();
    t_renew(128'h6161, 64'h6262, 1);
    t_integ();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule